// File: doc/BRIEF.md
# Data Breakpoint Address Matcher

This block watches the load and store traffic of a processor's data port and flags any access that falls inside one of several programmable address regions. It has a parameterised number of watch channels. Each channel holds a watch address and a control word. The control word enables loads and/or stores and carries a small mask field that sets the size of the region. Software programs the channels through a simple register write port and can read any channel back through a separate read port.

The hit output is combinational from the access inputs. It is asserted in the same cycle that the access is presented, so the pipeline can raise a debug stop before the access takes effect. When several channels match, the lowest-numbered one is reported. If the mask field is malformed, meaning its ones do not form one run starting at its top bit, it is truncated at its first zero bit. The watched region therefore always stays a naturally aligned power-of-two block. Dispatching the resulting debug exception is left to the surrounding core.

Top module: `dbpMatcher`

## Requirements
- R1: After reset every channel's address and control registers read back as zero, and no access produces a hit.
- R2: A write with `cfgWrSel`=0 stores the full data word in the addressed channel's address register. A write with `cfgWrSel`=1 stores the control word: bit 31 is store-enable, bit 30 is load-enable and bits 5:0 are the raw mask field. The control word reads back with all other bits zero and with the mask exactly as written.
- R3: A register write changes matching only for accesses presented in a later cycle. An access presented in the same cycle as the write is matched against the old register values.
- R4: A store (`accIsStore`=1) can match a channel only if its store-enable is set. A load (`accIsStore`=0) can match only if its load-enable is set.
- R5: A channel whose two enables are both clear never matches, whatever its mask and address.
- R6: Address bits 31:6 are always compared. Address bit i (i<6) is compared only when effective mask bit i is 1. An access matches when every compared bit equals the channel's address register. A mask of 0x3F therefore watches a single byte, and a mask of 0x00 watches the aligned 64-byte block.
- R7: The effective mask keeps the raw mask bits from bit 5 downward only up to the first zero bit, and clears every bit below it. For example, raw 0x35 acts as 0x30 (a 16-byte block) and raw 0x1F acts as 0x00 (a 64-byte block).
- R8: `hitValid` is combinational in the cycle the access is presented, and it is never asserted while `accValid` is low.
- R9: When several channels match one access, `hitCh` gives the lowest-numbered matching channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrSel | input | 1 | Write target: 0 address register, 1 control register |
| cfgWrCh | input | 2 | Channel written |
| cfgWrData | input | 32 | Write data |
| cfgRdCh | input | 2 | Channel read back |
| cfgRdSel | input | 1 | Readback target: 0 address, 1 control |
| cfgRdData | output | 32 | Readback data (combinational) |
| accValid | input | 1 | A data access is presented this cycle |
| accIsStore | input | 1 | 1 for a store, 0 for a load |
| accAddr | input | 32 | Byte address of the access |
| hitValid | output | 1 | The access matches at least one channel |
| hitCh | output | 2 | Lowest-numbered matching channel |

## Verification
The assertions check four things on every cycle. A hit never appears without an access. The reported channel is the lowest bit of the per-channel match vector, and the hit flag agrees with that vector. A write is visible on the readback port one cycle later, with the control word trimmed to its defined bits. The bench scenarios are needed for everything that depends on the stored contents. These include the load/store enable qualification, the region sizes produced by the mask, the truncation of malformed masks and the old-value behaviour of an access presented alongside a write.

// File: rtl/dbpPkg.sv
package dbpPkg;

  // Register selector used on both the write and the readback port.
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CTRL = 1'b1
  } regSel_e;

  // Per-channel write strobes issued by control to the datapath.
  typedef struct packed {
    logic wrAddr;
    logic wrCtrl;
  } chanStrobe_t;

endpackage

// File: rtl/dbpMaskNorm.sv
module dbpMaskNorm #(
  parameter int MASK_W = 6
) (
  input  logic [MASK_W-1:0] rawMask,
  output logic [MASK_W-1:0] normMask
);

  // runOnes[i] is set when raw bits MASK_W-1 down to i are all ones.
  logic [MASK_W:0] runOnes;

  assign runOnes[MASK_W] = 1'b1;

  for (genvar i = MASK_W - 1; i >= 0; i--) begin : g_run
    assign runOnes[i]  = runOnes[i+1] & rawMask[i];
    assign normMask[i] = runOnes[i];
  end

endmodule

// File: rtl/dbpControl.sv
module dbpControl
  import dbpPkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     cfgWrEn,
  input  logic                     cfgWrSel,
  input  logic [CH_W-1:0]          cfgWrCh,
  input  logic [NUM_CH-1:0]        hitVec,
  output chanStrobe_t [NUM_CH-1:0] strobes,
  output logic                     hitValid,
  output logic [CH_W-1:0]          hitCh
);

  // Write decode: one strobe pair per channel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic chSel;
    assign chSel = cfgWrEn && (cfgWrCh == CH_W'(c));
    assign strobes[c].wrAddr = chSel && (cfgWrSel == SEL_ADDR);
    assign strobes[c].wrCtrl = chSel && (cfgWrSel == SEL_CTRL);
  end

  // Priority select: lowest-numbered matching channel wins.
  always_comb begin
    hitValid = 1'b0;
    hitCh    = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (hitVec[c]) begin
        hitValid = 1'b1;
        hitCh    = CH_W'(c);
      end
    end
  end

endmodule

// File: rtl/dbpDatapath.sv
module dbpDatapath
  import dbpPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int MASK_W = 6,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ST_BIT = ADDR_W - 1,
  localparam int LD_BIT = ADDR_W - 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chanStrobe_t [NUM_CH-1:0] strobes,
  input  logic [ADDR_W-1:0]        wrData,
  input  logic [CH_W-1:0]          rdCh,
  input  logic                     rdSel,
  output logic [ADDR_W-1:0]        rdData,
  input  logic                     accValid,
  input  logic                     accIsStore,
  input  logic [ADDR_W-1:0]        accAddr,
  output logic [NUM_CH-1:0]        hitVec
);

  logic [ADDR_W-1:0] addrQ    [NUM_CH];
  logic [ADDR_W-1:0] ctrlWord [NUM_CH];
  logic [MASK_W-1:0] maskQ    [NUM_CH];
  logic [NUM_CH-1:0] ldEnQ;
  logic [NUM_CH-1:0] stEnQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MASK_W-1:0] normMask;
    logic              highEq;
    logic              lowEq;
    logic              typeOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[c] <= '0;
        maskQ[c] <= '0;
        ldEnQ[c] <= 1'b0;
        stEnQ[c] <= 1'b0;
      end else begin
        if (strobes[c].wrAddr) begin
          addrQ[c] <= wrData;
        end
        if (strobes[c].wrCtrl) begin
          maskQ[c] <= wrData[MASK_W-1:0];
          ldEnQ[c] <= wrData[LD_BIT];
          stEnQ[c] <= wrData[ST_BIT];
        end
      end
    end

    dbpMaskNorm #(.MASK_W(MASK_W)) i_norm (
      .rawMask (maskQ[c]),
      .normMask(normMask)
    );

    assign highEq = (accAddr[ADDR_W-1:MASK_W] == addrQ[c][ADDR_W-1:MASK_W]);
    assign lowEq  = (((accAddr[MASK_W-1:0] ^ addrQ[c][MASK_W-1:0]) & normMask) == '0);
    assign typeOk = accIsStore ? stEnQ[c] : ldEnQ[c];
    assign hitVec[c] = accValid && typeOk && highEq && lowEq;

    always_comb begin
      ctrlWord[c]               = '0;
      ctrlWord[c][ST_BIT]       = stEnQ[c];
      ctrlWord[c][LD_BIT]       = ldEnQ[c];
      ctrlWord[c][MASK_W-1:0]   = maskQ[c];
    end
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdCh == CH_W'(c)) begin
        rdData = (rdSel == SEL_CTRL) ? ctrlWord[c] : addrQ[c];
      end
    end
  end

endmodule

// File: rtl/dbpMatcher.sv
module dbpMatcher
  import dbpPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int MASK_W = 6,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWrSel,
  input  logic [CH_W-1:0]   cfgWrCh,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [CH_W-1:0]   cfgRdCh,
  input  logic              cfgRdSel,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              accValid,
  input  logic              accIsStore,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              hitValid,
  output logic [CH_W-1:0]   hitCh
);

  chanStrobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH-1:0]        hitVec;

  dbpControl #(.NUM_CH(NUM_CH)) i_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgWrSel(cfgWrSel),
    .cfgWrCh (cfgWrCh),
    .hitVec  (hitVec),
    .strobes (strobes),
    .hitValid(hitValid),
    .hitCh   (hitCh)
  );

  dbpDatapath #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .MASK_W(MASK_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (cfgWrData),
    .rdCh      (cfgRdCh),
    .rdSel     (cfgRdSel),
    .rdData    (cfgRdData),
    .accValid  (accValid),
    .accIsStore(accIsStore),
    .accAddr   (accAddr),
    .hitVec    (hitVec)
  );

endmodule

// File: rtl/dbpMatcherChk.sv
module dbpMatcherChk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int MASK_W = 6,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              cfgWrSel,
  input logic [CH_W-1:0]   cfgWrCh,
  input logic [ADDR_W-1:0] cfgWrData,
  input logic [CH_W-1:0]   cfgRdCh,
  input logic              cfgRdSel,
  input logic [ADDR_W-1:0] cfgRdData,
  input logic              accValid,
  input logic              hitValid,
  input logic [CH_W-1:0]   hitCh,
  input logic [NUM_CH-1:0] hitVec
);

  logic [ADDR_W-1:0] ctrlKeep;
  logic [NUM_CH-1:0] belowHit;

  always_comb begin
    ctrlKeep              = '0;
    ctrlKeep[ADDR_W-1]    = 1'b1;
    ctrlKeep[ADDR_W-2]    = 1'b1;
    ctrlKeep[MASK_W-1:0]  = '1;
  end

  assign belowHit = hitVec & ((NUM_CH'(1) << hitCh) - NUM_CH'(1));

  // R8
  hit_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> accValid);

  // R9
  hit_flag_agrees_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid == (|hitVec));

  // R9
  hit_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitVec[hitCh] && (belowHit == '0)));

  // R2
  addr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgWrEn) && !$past(cfgWrSel) && !cfgRdSel
     && (cfgRdCh == $past(cfgWrCh))) |-> (cfgRdData == $past(cfgWrData)));

  // R2
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgWrEn) && $past(cfgWrSel) && cfgRdSel
     && (cfgRdCh == $past(cfgWrCh))) |-> (cfgRdData == ($past(cfgWrData) & ctrlKeep)));

endmodule

bind dbpMatcher dbpMatcherChk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .MASK_W(MASK_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .cfgWrSel (cfgWrSel),
  .cfgWrCh  (cfgWrCh),
  .cfgWrData(cfgWrData),
  .cfgRdCh  (cfgRdCh),
  .cfgRdSel (cfgRdSel),
  .cfgRdData(cfgRdData),
  .accValid (accValid),
  .hitValid (hitValid),
  .hitCh    (hitCh),
  .hitVec   (hitVec)
);

// File: tb/test_dbpMatcher.sv
`timescale 1ns/1ps
module test_dbpMatcher;

  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic        cfgWrSel;
  logic [1:0]  cfgWrCh;
  logic [31:0] cfgWrData;
  logic [1:0]  cfgRdCh;
  logic        cfgRdSel;
  logic [31:0] cfgRdData;
  logic        accValid;
  logic        accIsStore;
  logic [31:0] accAddr;
  logic        hitValid;
  logic [1:0]  hitCh;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbpMatcher #(.NUM_CH(NUM_CH)) i_dbpMatcher (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrCh(cfgWrCh), .cfgWrData(cfgWrData),
    .cfgRdCh(cfgRdCh), .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData),
    .accValid(accValid), .accIsStore(accIsStore), .accAddr(accAddr),
    .hitValid(hitValid), .hitCh(hitCh)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int ch, input bit sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrCh = CH_W'(ch); cfgWrSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rdCheck(input int ch, input bit sel, input logic [31:0] exp,
                         input string req);
    @(negedge clk);
    cfgRdCh = CH_W'(ch); cfgRdSel = sel;
    #2;
    check(cfgRdData == exp, req, cfgRdData, exp);
  endtask

  // Present one access and compare {hitValid, hitCh}.
  task automatic accCheck(input bit valid, input bit isStore, input logic [31:0] addr,
                          input bit expHit, input int expCh, input string req);
    @(negedge clk);
    accValid = valid; accIsStore = isStore; accAddr = addr;
    #2;
    check(hitValid == expHit && (!expHit || hitCh == CH_W'(expCh)), req,
          {hitValid, 29'd0, hitCh}, {expHit, 29'd0, expHit ? 2'(expCh) : hitCh});
    accValid = 1'b0;
  endtask

  task automatic clearAll();
    for (int c = 0; c < NUM_CH; c++) begin
      wrReg(c, 1'b1, 32'h0);
      wrReg(c, 1'b0, 32'h0);
    end
  endtask

  task automatic tReset();
    for (int c = 0; c < NUM_CH; c++) begin
      rdCheck(c, 1'b0, 32'h0, "R1 addr reset");
      rdCheck(c, 1'b1, 32'h0, "R1 ctrl reset");
    end
    accCheck(1'b1, 1'b0, 32'h0, 1'b0, 0, "R1 no hit after reset load");
    accCheck(1'b1, 1'b1, 32'h0, 1'b0, 0, "R1 no hit after reset store");
  endtask

  task automatic tReadback();
    wrReg(1, 1'b0, 32'h1234_5678);
    wrReg(1, 1'b1, 32'hFFFF_FFFF);
    rdCheck(1, 1'b0, 32'h1234_5678, "R2 addr readback");
    rdCheck(1, 1'b1, 32'hC000_003F, "R2 ctrl readback trimmed");
    wrReg(1, 1'b1, 32'h4000_0035);
    rdCheck(1, 1'b1, 32'h4000_0035, "R2 raw mask readback");
    clearAll();
  endtask

  task automatic tSameCycle();
    wrReg(0, 1'b0, 32'h0000_1000);
    wrReg(0, 1'b1, 32'h4000_003F);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrCh = 2'd0; cfgWrSel = 1'b0; cfgWrData = 32'h0000_2000;
    accValid = 1'b1; accIsStore = 1'b0; accAddr = 32'h0000_1000;
    #2;
    check(hitValid == 1'b1 && hitCh == 2'd0, "R3 same-cycle access sees old addr",
          {31'd0, hitValid}, 32'd1);
    @(negedge clk);
    cfgWrEn = 1'b0; accValid = 1'b0;
    accCheck(1'b1, 1'b0, 32'h0000_1000, 1'b0, 0, "R3 old addr gone next cycle");
    accCheck(1'b1, 1'b0, 32'h0000_2000, 1'b1, 0, "R3 new addr active");
    clearAll();
  endtask

  task automatic tTypeEnables();
    wrReg(2, 1'b0, 32'h0000_3000);
    wrReg(2, 1'b1, 32'h4000_003F);
    accCheck(1'b1, 1'b0, 32'h0000_3000, 1'b1, 2, "R4 load-only load hits");
    accCheck(1'b1, 1'b1, 32'h0000_3000, 1'b0, 0, "R4 load-only store misses");
    wrReg(2, 1'b1, 32'h8000_003F);
    accCheck(1'b1, 1'b1, 32'h0000_3000, 1'b1, 2, "R4 store-only store hits");
    accCheck(1'b1, 1'b0, 32'h0000_3000, 1'b0, 0, "R4 store-only load misses");
    wrReg(2, 1'b1, 32'h0000_003F);
    accCheck(1'b1, 1'b0, 32'h0000_3000, 1'b0, 0, "R5 disabled load misses");
    accCheck(1'b1, 1'b1, 32'h0000_3000, 1'b0, 0, "R5 disabled store misses");
    clearAll();
  endtask

  task automatic tMaskRegion();
    wrReg(0, 1'b0, 32'h4000_0040);
    wrReg(0, 1'b1, 32'hC000_0000);
    accCheck(1'b1, 1'b1, 32'h4000_007F, 1'b1, 0, "R6 64B block top byte");
    accCheck(1'b1, 1'b1, 32'h4000_0080, 1'b0, 0, "R6 64B block above");
    accCheck(1'b1, 1'b0, 32'h4000_003F, 1'b0, 0, "R6 64B block below");
    wrReg(0, 1'b0, 32'h4000_0047);
    wrReg(0, 1'b1, 32'hC000_003C);
    accCheck(1'b1, 1'b0, 32'h4000_0044, 1'b1, 0, "R6 4B block ignores low bits");
    accCheck(1'b1, 1'b0, 32'h4000_0048, 1'b0, 0, "R6 4B block next word");
    wrReg(0, 1'b1, 32'hC000_003F);
    accCheck(1'b1, 1'b0, 32'h4000_0047, 1'b1, 0, "R6 exact byte");
    accCheck(1'b1, 1'b0, 32'h4000_0046, 1'b0, 0, "R6 exact neighbour");
    accCheck(1'b1, 1'b0, 32'hC000_0047, 1'b0, 0, "R6 high bit differs");
    clearAll();
  endtask

  task automatic tMalformedMask();
    wrReg(2, 1'b0, 32'h5000_0000);
    wrReg(2, 1'b1, 32'h4000_0035);
    accCheck(1'b1, 1'b0, 32'h5000_000F, 1'b1, 2, "R7 0x35 acts as 16B block");
    accCheck(1'b1, 1'b0, 32'h5000_0010, 1'b0, 0, "R7 0x35 outside block");
    wrReg(2, 1'b1, 32'h4000_001F);
    accCheck(1'b1, 1'b0, 32'h5000_003F, 1'b1, 2, "R7 0x1F acts as 64B block");
    accCheck(1'b1, 1'b0, 32'h5000_0040, 1'b0, 0, "R7 0x1F outside block");
    clearAll();
  endtask

  task automatic tNoValid();
    wrReg(0, 1'b1, 32'hC000_0000);
    accCheck(1'b0, 1'b0, 32'h0000_0000, 1'b0, 0, "R8 no hit without accValid");
    accCheck(1'b1, 1'b0, 32'h0000_0000, 1'b1, 0, "R8 same-cycle hit with accValid");
    clearAll();
  endtask

  task automatic tPriority();
    wrReg(1, 1'b0, 32'h0000_6000);
    wrReg(1, 1'b1, 32'hC000_0000);
    wrReg(3, 1'b0, 32'h0000_6010);
    wrReg(3, 1'b1, 32'hC000_003C);
    accCheck(1'b1, 1'b0, 32'h0000_6010, 1'b1, 1, "R9 lowest channel wins");
    wrReg(1, 1'b1, 32'h0000_0000);
    accCheck(1'b1, 1'b0, 32'h0000_6010, 1'b1, 3, "R9 next channel after disable");
    clearAll();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrSel = 1'b0; cfgWrCh = '0; cfgWrData = '0;
    cfgRdCh = '0; cfgRdSel = 1'b0; accValid = 1'b0; accIsStore = 1'b0; accAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tReadback();
    tSameCycle();
    tTypeEnables();
    tMaskRegion();
    tMalformedMask();
    tNoValid();
    tPriority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule